// File: doc/BRIEF.md
# CRTC Timing Override Unit

This block sits between the register file of a 6845-style CRT controller and the raster timing generator. It turns the programmed base timing values into the values the counters actually use. Two banks of eight override bytes are held upstream: one for text mode and one for graphics mode. The graphics-mode bit of the mode control register picks the active bank.

Inside the active bank, some bytes replace a base timing field outright. Others add a wrapping offset to a base field: the horizontal sync position, the vertical sync position and the cursor scan lines. The last byte also carries the line re-scan (line repeat) selector, which is decoded and passed on to the scan logic.

An enable input bypasses the whole unit, so the base values reach the timing generator unchanged. The outputs are purely combinational from the inputs. A change of mode bit or of any register therefore takes effect in the same cycle. The clock and reset serve only the built-in property checks. The counters and sync generators that consume these values are outside the block.

Top module: `crtc_timing_override`

## Requirements
- R1: When ovr_en is 0, every eff_* output equals its base_* input and rescan_mode is 0, whatever the banks and mode bit hold.
- R2: When ovr_en is 1, the override bytes come from text_bank if gfx_mode is 0 and from gfx_bank if gfx_mode is 1. Override byte k occupies bits [8k+7:8k] of the bank.
- R3: With ovr_en 1, byte 0 replaces the horizontal total (eff_htotal) and byte 3 replaces the sync pulse width (eff_sync_width), all 8 bits.
- R4: With ovr_en 1, eff_hsync_pos equals base_hsync_pos plus byte 1, modulo 256.
- R5: With ovr_en 1, eff_vsync_pos equals the low 7 bits of (base_vsync_pos plus byte 2).
- R6: With ovr_en 1, the low 7 bits of byte 4 replace the vertical total. The low 5 bits of byte 5 replace the vertical total adjust. The low 5 bits of byte 6 replace the maximum scan line.
- R7: With ovr_en 1, rescan_mode equals bits 6:5 of byte 7. The codes are 0 for none, 1 for every other line, 2 for alternate lines with variant spacing, and 3 for every line repeated.
- R8: With ovr_en 1, bits 3:0 of byte 7 are added modulo 32 to base_cur_end. If bit 7 of byte 7 is 0, the same amount is also added to base_cur_start. If bit 7 is 1, eff_cur_start equals base_cur_start.
- R9: The outputs follow their inputs within the same cycle with no register in the path, including a change of gfx_mode alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in property checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| ovr_en | input | 1 | 1 applies overrides, 0 passes base values through |
| gfx_mode | input | 1 | Mode control graphics bit: 0 text bank, 1 graphics bank |
| base_htotal | input | 8 | Base horizontal total |
| base_hsync_pos | input | 8 | Base horizontal sync position |
| base_sync_width | input | 8 | Base sync pulse width |
| base_vtotal | input | 7 | Base vertical total |
| base_vadjust | input | 5 | Base vertical total adjust |
| base_vsync_pos | input | 7 | Base vertical sync position |
| base_max_scan | input | 5 | Base maximum scan line |
| base_cur_start | input | 5 | Base cursor start line |
| base_cur_end | input | 5 | Base cursor end line |
| text_bank | input | 64 | Eight override bytes for text mode |
| gfx_bank | input | 64 | Eight override bytes for graphics mode |
| eff_htotal | output | 8 | Effective horizontal total |
| eff_hsync_pos | output | 8 | Effective horizontal sync position |
| eff_sync_width | output | 8 | Effective sync pulse width |
| eff_vtotal | output | 7 | Effective vertical total |
| eff_vadjust | output | 5 | Effective vertical total adjust |
| eff_vsync_pos | output | 7 | Effective vertical sync position |
| eff_max_scan | output | 5 | Effective maximum scan line |
| eff_cur_start | output | 5 | Effective cursor start line |
| eff_cur_end | output | 5 | Effective cursor end line |
| rescan_mode | output | 2 | Decoded line re-scan selector |

## Verification
The two banks are loaded with different random contents. A bank swap is then visible on every output, and a check separates a mis-wired bank select from a mis-wired field. Directed cases drive all-ones bases with large offsets, which exposes a missing wrap or a wrong truncation width in the sync adders. Both settings of the cursor scope bit are driven so that the start and end paths are told apart. The four re-scan codes are stepped through in order. Toggling the mode bit alone, or clearing ovr_en while the banks stay loaded, shows that nothing is latched and that the bypass is complete.

// File: rtl/crtc_ovr_pkg.sv
// Shared constants and types for the CRTC timing override unit.
// Assumes eight-byte override banks with a fixed byte meaning per offset.
package crtc_ovr_pkg;
    localparam int OVR_BYTES = 8;
    localparam int BYTE_W    = 8;
    localparam int VERT_W    = 7;
    localparam int SCAN_W    = 5;

    localparam int OFS_HTOTAL = 0;
    localparam int OFS_HSYNC  = 1;
    localparam int OFS_VSYNC  = 2;
    localparam int OFS_SWIDTH = 3;
    localparam int OFS_VTOTAL = 4;
    localparam int OFS_VADJ   = 5;
    localparam int OFS_MAXSCN = 6;
    localparam int OFS_CTRL   = 7;

    localparam int CTRL_CUR_LSB  = 0;
    localparam int CTRL_CUR_W    = 4;
    localparam int CTRL_RSC_LSB  = 5;
    localparam int CTRL_ENDONLY  = 7;

    typedef enum logic [1:0] {
        RESCAN_NONE    = 2'd0,
        RESCAN_ALT     = 2'd1,
        RESCAN_ALT_VAR = 2'd2,
        RESCAN_EVERY   = 2'd3
    } rescan_e;
endpackage

// File: rtl/crtc_ovr_bank_sel.sv
// Picks the text or graphics override bank and splits it into bytes.
// Assumes both banks are stable register outputs; purely combinational.
module crtc_ovr_bank_sel #(
    parameter int NBYTES = 8,
    parameter int BW     = 8
) (
    input  logic                       gfx_mode,
    input  logic [NBYTES*BW-1:0]       text_bank,
    input  logic [NBYTES*BW-1:0]       gfx_bank,
    output logic [NBYTES-1:0][BW-1:0]  sel_bytes
);
    // One two-way mux per override byte.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign sel_bytes[k] = gfx_mode ? gfx_bank[k*BW +: BW]
                                       : text_bank[k*BW +: BW];
    end
endmodule

// File: rtl/crtc_ovr_field.sv
// Merges one override byte into one base timing field.
// ADD=1: base plus byte, wrapping at the field width; ADD=0: low bits replace.
// Assumes W <= BW. With en low the base value passes unchanged.
module crtc_ovr_field #(
    parameter int W   = 8,
    parameter int BW  = 8,
    parameter bit ADD = 1'b0
) (
    input  logic          en,
    input  logic [W-1:0]  base,
    input  logic [BW-1:0] ovr,
    output logic [W-1:0]  eff
);
    logic [W-1:0] merged;

    if (ADD) begin : g_add
        // Wrapping sum; truncation to W keeps the mod-256 result's low bits.
        assign merged = base + ovr[W-1:0];
    end else begin : g_rep
        // Straight replacement by the low bits of the override byte.
        assign merged = ovr[W-1:0];
    end

    if (W < BW) begin : g_pad
        logic unused_hi;
        assign unused_hi = &{1'b0, ovr[BW-1:W]};
    end

    // Bypass selection.
    assign eff = en ? merged : base;
endmodule

// File: rtl/crtc_rescan_decode.sv
// Decodes the line re-scan selector from the control override byte.
// Assumes the selector sits in bits 6:5; reports no re-scan when disabled.
module crtc_rescan_decode
    import crtc_ovr_pkg::*;
(
    input  logic       en,
    input  logic [1:0] sel,
    output logic [1:0] mode
);
    rescan_e dec;

    // Map the raw field onto the named re-scan variants.
    always_comb begin
        dec = RESCAN_NONE;
        if (en) begin
            case (sel)
                2'd1:    dec = RESCAN_ALT;
                2'd2:    dec = RESCAN_ALT_VAR;
                2'd3:    dec = RESCAN_EVERY;
                default: dec = RESCAN_NONE;
            endcase
        end
    end

    assign mode = dec;
endmodule

// File: rtl/crtc_timing_override.sv
// CRTC timing override unit: applies the active mode's override bank to the
// base 6845-style timing fields and decodes the line re-scan selector.
// Assumes registered inputs; outputs are combinational. clk and rst_n only
// clock the embedded property checks.
module crtc_timing_override
    import crtc_ovr_pkg::*;
#(
    parameter int NUM_OVR = OVR_BYTES,
    parameter int DATA_W  = BYTE_W,
    parameter int V_W     = VERT_W,
    parameter int S_W     = SCAN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ovr_en,
    input  logic                      gfx_mode,
    input  logic [DATA_W-1:0]         base_htotal,
    input  logic [DATA_W-1:0]         base_hsync_pos,
    input  logic [DATA_W-1:0]         base_sync_width,
    input  logic [V_W-1:0]            base_vtotal,
    input  logic [S_W-1:0]            base_vadjust,
    input  logic [V_W-1:0]            base_vsync_pos,
    input  logic [S_W-1:0]            base_max_scan,
    input  logic [S_W-1:0]            base_cur_start,
    input  logic [S_W-1:0]            base_cur_end,
    input  logic [NUM_OVR*DATA_W-1:0] text_bank,
    input  logic [NUM_OVR*DATA_W-1:0] gfx_bank,
    output logic [DATA_W-1:0]         eff_htotal,
    output logic [DATA_W-1:0]         eff_hsync_pos,
    output logic [DATA_W-1:0]         eff_sync_width,
    output logic [V_W-1:0]            eff_vtotal,
    output logic [S_W-1:0]            eff_vadjust,
    output logic [V_W-1:0]            eff_vsync_pos,
    output logic [S_W-1:0]            eff_max_scan,
    output logic [S_W-1:0]            eff_cur_start,
    output logic [S_W-1:0]            eff_cur_end,
    output logic [1:0]                rescan_mode
);
    localparam int CUR_PAD = DATA_W - CTRL_CUR_W;

    logic [NUM_OVR-1:0][DATA_W-1:0] ob;
    logic [DATA_W-1:0]              cur_adj;
    logic                           start_en;
    logic                           unused_ctrl;

    crtc_ovr_bank_sel #(.NBYTES(NUM_OVR), .BW(DATA_W)) i_bank (
        .gfx_mode (gfx_mode),
        .text_bank(text_bank),
        .gfx_bank (gfx_bank),
        .sel_bytes(ob)
    );

    // Cursor adjustment amount and its scope (end only, or start and end).
    assign cur_adj     = {{CUR_PAD{1'b0}}, ob[OFS_CTRL][CTRL_CUR_LSB +: CTRL_CUR_W]};
    assign start_en    = ovr_en & ~ob[OFS_CTRL][CTRL_ENDONLY];
    assign unused_ctrl = &{1'b0, ob[OFS_CTRL][4]};

    crtc_ovr_field #(.W(DATA_W), .BW(DATA_W), .ADD(1'b0)) i_htot (
        .en(ovr_en), .base(base_htotal), .ovr(ob[OFS_HTOTAL]), .eff(eff_htotal));
    crtc_ovr_field #(.W(DATA_W), .BW(DATA_W), .ADD(1'b1)) i_hsyn (
        .en(ovr_en), .base(base_hsync_pos), .ovr(ob[OFS_HSYNC]), .eff(eff_hsync_pos));
    crtc_ovr_field #(.W(DATA_W), .BW(DATA_W), .ADD(1'b0)) i_swid (
        .en(ovr_en), .base(base_sync_width), .ovr(ob[OFS_SWIDTH]), .eff(eff_sync_width));
    crtc_ovr_field #(.W(V_W), .BW(DATA_W), .ADD(1'b0)) i_vtot (
        .en(ovr_en), .base(base_vtotal), .ovr(ob[OFS_VTOTAL]), .eff(eff_vtotal));
    crtc_ovr_field #(.W(S_W), .BW(DATA_W), .ADD(1'b0)) i_vadj (
        .en(ovr_en), .base(base_vadjust), .ovr(ob[OFS_VADJ]), .eff(eff_vadjust));
    crtc_ovr_field #(.W(V_W), .BW(DATA_W), .ADD(1'b1)) i_vsyn (
        .en(ovr_en), .base(base_vsync_pos), .ovr(ob[OFS_VSYNC]), .eff(eff_vsync_pos));
    crtc_ovr_field #(.W(S_W), .BW(DATA_W), .ADD(1'b0)) i_mscn (
        .en(ovr_en), .base(base_max_scan), .ovr(ob[OFS_MAXSCN]), .eff(eff_max_scan));
    crtc_ovr_field #(.W(S_W), .BW(DATA_W), .ADD(1'b1)) i_cst (
        .en(start_en), .base(base_cur_start), .ovr(cur_adj), .eff(eff_cur_start));
    crtc_ovr_field #(.W(S_W), .BW(DATA_W), .ADD(1'b1)) i_cend (
        .en(ovr_en), .base(base_cur_end), .ovr(cur_adj), .eff(eff_cur_end));

    crtc_rescan_decode i_rsc (
        .en  (ovr_en),
        .sel (ob[OFS_CTRL][CTRL_RSC_LSB +: 2]),
        .mode(rescan_mode)
    );

    // Bypass leaves every timing field at its base value.
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_en |-> (eff_htotal == base_htotal && eff_hsync_pos == base_hsync_pos
                     && eff_vsync_pos == base_vsync_pos && eff_cur_start == base_cur_start
                     && eff_cur_end == base_cur_end && rescan_mode == 2'd0));

    // Graphics mode takes the horizontal total from the graphics bank.
    assert_gfx_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && gfx_mode) |-> eff_htotal == gfx_bank[OFS_HTOTAL*DATA_W +: DATA_W]);

    // Text mode takes the sync width from the text bank.
    assert_text_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && !gfx_mode) |-> eff_sync_width == text_bank[OFS_SWIDTH*DATA_W +: DATA_W]);

    // Horizontal sync offset wraps modulo 256.
    assert_hsync_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |-> (eff_hsync_pos - base_hsync_pos) ==
            (gfx_mode ? gfx_bank[OFS_HSYNC*DATA_W +: DATA_W]
                      : text_bank[OFS_HSYNC*DATA_W +: DATA_W]));

    // End-only scope keeps the cursor start at its base.
    assert_cursor_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && (gfx_mode ? gfx_bank[OFS_CTRL*DATA_W + CTRL_ENDONLY]
                             : text_bank[OFS_CTRL*DATA_W + CTRL_ENDONLY]))
        |-> eff_cur_start == base_cur_start);

    // No hidden state: unchanged inputs give unchanged outputs.
    assert_no_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(ovr_en) && $stable(gfx_mode) && $stable(text_bank) && $stable(gfx_bank)
         && $stable(base_hsync_pos) && $stable(base_vsync_pos))
        |-> ($stable(eff_hsync_pos) && $stable(eff_vsync_pos) && $stable(rescan_mode)));
endmodule

// File: tb/test_crtc_timing_override.sv
// Self-checking bench for the CRTC timing override unit: directed corners
// plus seeded random stimulus against a bench-side reference model.
module test_crtc_timing_override;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovr_en = 1'b0, gfx_mode = 1'b0;
    logic [7:0]  b_ht = 8'h0, b_hs = 8'h0, b_sw = 8'h0;
    logic [6:0]  b_vt = 7'h0, b_vs = 7'h0;
    logic [4:0]  b_va = 5'h0, b_ms = 5'h0, b_cs = 5'h0, b_ce = 5'h0;
    logic [63:0] tbank = 64'h0, gbank = 64'h0;
    logic [7:0]  e_ht, e_hs, e_sw;
    logic [6:0]  e_vt, e_vs;
    logic [4:0]  e_va, e_ms, e_cs, e_ce;
    logic [1:0]  e_rm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    crtc_timing_override i_crtc_timing_override (
        .clk(clk), .rst_n(rst_n), .ovr_en(ovr_en), .gfx_mode(gfx_mode),
        .base_htotal(b_ht), .base_hsync_pos(b_hs), .base_sync_width(b_sw),
        .base_vtotal(b_vt), .base_vadjust(b_va), .base_vsync_pos(b_vs),
        .base_max_scan(b_ms), .base_cur_start(b_cs), .base_cur_end(b_ce),
        .text_bank(tbank), .gfx_bank(gbank),
        .eff_htotal(e_ht), .eff_hsync_pos(e_hs), .eff_sync_width(e_sw),
        .eff_vtotal(e_vt), .eff_vadjust(e_va), .eff_vsync_pos(e_vs),
        .eff_max_scan(e_ms), .eff_cur_start(e_cs), .eff_cur_end(e_ce),
        .rescan_mode(e_rm)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] obyte(input int k);
        return gfx_mode ? gbank[k*8 +: 8] : tbank[k*8 +: 8];
    endfunction

    // Reference model built from the requirements, checked after settling.
    task automatic check_all(input string ctx);
        logic [7:0] c, x;
        logic [4:0] adj;
        #1;
        c   = obyte(7);
        adj = {1'b0, c[3:0]};
        if (!ovr_en) begin
            chk({ctx, " R1 htotal"}, e_ht, b_ht);
            chk({ctx, " R1 hsync"},  e_hs, b_hs);
            chk({ctx, " R1 swidth"}, e_sw, b_sw);
            chk({ctx, " R1 vtotal"}, {1'b0, e_vt}, {1'b0, b_vt});
            chk({ctx, " R1 vadj"},   {3'b0, e_va}, {3'b0, b_va});
            chk({ctx, " R1 vsync"},  {1'b0, e_vs}, {1'b0, b_vs});
            chk({ctx, " R1 maxscan"},{3'b0, e_ms}, {3'b0, b_ms});
            chk({ctx, " R1 curst"},  {3'b0, e_cs}, {3'b0, b_cs});
            chk({ctx, " R1 curend"}, {3'b0, e_ce}, {3'b0, b_ce});
            chk({ctx, " R1 rescan"}, {6'b0, e_rm}, 8'h0);
        end else begin
            chk({ctx, " R2 R3 htotal"}, e_ht, obyte(0));
            chk({ctx, " R3 swidth"},    e_sw, obyte(3));
            x = b_hs + obyte(1);
            chk({ctx, " R4 hsync"}, e_hs, x);
            x = {1'b0, b_vs} + obyte(2);
            chk({ctx, " R5 vsync"}, {1'b0, e_vs}, {1'b0, x[6:0]});
            x = obyte(4);
            chk({ctx, " R6 vtotal"}, {1'b0, e_vt}, {1'b0, x[6:0]});
            x = obyte(5);
            chk({ctx, " R6 vadj"}, {3'b0, e_va}, {3'b0, x[4:0]});
            x = obyte(6);
            chk({ctx, " R6 maxscan"}, {3'b0, e_ms}, {3'b0, x[4:0]});
            chk({ctx, " R7 rescan"}, {6'b0, e_rm}, {6'b0, c[6:5]});
            chk({ctx, " R8 curend"}, {3'b0, e_ce}, {3'b0, b_ce + adj});
            chk({ctx, " R8 curst"}, {3'b0, e_cs},
                {3'b0, (c[7] ? b_cs : b_cs + adj)});
        end
    endtask

    task automatic randomize_all();
        b_ht = 8'($urandom); b_hs = 8'($urandom); b_sw = 8'($urandom);
        b_vt = 7'($urandom); b_vs = 7'($urandom); b_va = 5'($urandom);
        b_ms = 5'($urandom); b_cs = 5'($urandom); b_ce = 5'($urandom);
        tbank = {$urandom, $urandom}; gbank = {$urandom, $urandom};
    endtask

    initial begin
        void'($urandom(32'd4242));
        randomize_all();
        @(negedge clk);
        check_all("reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: banks loaded, overrides off.
        @(negedge clk); ovr_en = 1'b0; gfx_mode = 1'b1;
        check_all("bypass");

        // R2: same bases, both banks distinct, mode bit toggled alone (R9).
        @(negedge clk); ovr_en = 1'b1; gfx_mode = 1'b0;
        tbank = 64'h0123_4567_89AB_CDEF; gbank = 64'hFEDC_BA98_7654_3210;
        check_all("text bank");
        gfx_mode = 1'b1;
        check_all("R9 same-cycle mode flip");

        // R4/R5 wrap corners.
        @(negedge clk); gfx_mode = 1'b0;
        b_hs = 8'hFF; b_vs = 7'h7F;
        tbank = 64'h0000_0000_00FF_0200;
        check_all("wrap");
        chk("R4 hsync wrap value", e_hs, 8'h01);
        chk("R5 vsync wrap value", {1'b0, e_vs}, 8'h7E);

        // R8: cursor scope both ways, with wrap at 32.
        @(negedge clk); b_cs = 5'd30; b_ce = 5'd31;
        tbank[63:56] = 8'h0F;
        check_all("cursor both");
        chk("R8 start wrap", {3'b0, e_cs}, 8'd13);
        tbank[63:56] = 8'h8F;
        check_all("cursor end only");
        chk("R8 start held", {3'b0, e_cs}, 8'd30);

        // R7: each re-scan code in turn.
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            tbank[63:56] = {1'b0, 2'(m), 5'b0};
            check_all("rescan step");
            chk("R7 code", {6'b0, e_rm}, 8'(m));
        end

        // R6: replacement drops high bits of override bytes.
        @(negedge clk); tbank[55:32] = 24'hFF_FF_FF;
        check_all("R6 truncation");

        // Random sweep.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            randomize_all();
            ovr_en   = ($urandom % 4) != 0;
            gfx_mode = 1'($urandom);
            check_all("random");
        end

        // R1 again: clear enable with banks still loaded.
        @(negedge clk); ovr_en = 1'b0;
        check_all("bypass end");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule